// File: doc/BRIEF.md
# Configurable Maskable Interrupt Controller

This block gathers 32 interrupt lines into one interrupt request for a processor. It keeps two registers, an enable mask and a pending status, and both are reached through a plain register port. A write takes one clock and a read returns its data in the same cycle. Each line has one bit in each register, and bit i always belongs to line i. Software can therefore read the pending register and service the lowest-numbered set bit first.

A build-time parameter picks how pending bits behave. In level mode, a pending bit tracks its synchronised line and needs no acknowledge. In edge mode, a rising edge sets a sticky bit, and software clears it by writing 1 to that position. In legacy mode, any synchronised high level sets a sticky bit, and software clears it by writing 0 to that position. The usual way to do that is a read-modify-write with the target bit cleared. All lines pass through a two-flop synchroniser first. The request output is registered.

Top module: `irqc_top`

## Requirements
- R1: The block serves N_LINES lines (default 32). Bit i of every register belongs to line i. With cfg_sel=0, cfg_rdata shows the mask. With cfg_sel=1, it shows the pending register. The read is combinational in the same cycle.
- R2: The mask resets to all zeros. A write with cfg_sel=0 replaces the whole mask at the next edge. A 1 enables its line and a 0 disables it.
- R3: Each line passes through two flops before it is used. A level seen by the clock edge k is visible to the pending logic after edge k+1.
- R4: In edge mode, a 0-to-1 change between two consecutive synchronised samples sets the pending bit one edge later. The bit stays set until a pending write (cfg_sel=1) has a 1 in that position. A 0 in the write leaves the bit unchanged.
- R5: In level mode, each pending bit equals its synchronised line. Writes to the pending register have no effect.
- R6: In legacy mode, a synchronised high level sets the pending bit, and the bit stays set after the line falls. A pending write with a 0 in that position clears the bit. A 1 in the write leaves it unchanged.
- R7: If a set condition and a clear write hit the same bit in the same cycle, the bit stays pending.
- R8: Pending bits latch whether or not the line is masked. A masked pending bit can still be read back.
- R9: irq_o is registered. It is high after the edge that samples a nonzero AND of the pending and mask registers, and low otherwise.
- R10: Reset clears the synchroniser, the sticky pending bits, the mask and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N_LINES | Asynchronous interrupt lines |
| cfg_wr | input | 1 | Register write strobe, one cycle per write |
| cfg_sel | input | 1 | Register select: 0 selects the mask, 1 selects pending |
| cfg_wdata | input | N_LINES | Write data |
| cfg_rdata | output | N_LINES | Read data for the selected register |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Pending bits are due on the following schedule after a line changes at the port:
- In level mode, after the second clock edge.
- In edge and legacy modes, after the third clock edge.

irq_o follows one edge after the pending bit and the mask first overlap. A mask write shows on read-back after the next edge.

The bench drives its inputs 1 ns after a rising edge and compares at the falling edge. Its cycle model advances its own synchroniser, pending and request stages on the same edges, so every compare falls in a settled cycle. The directed cases count edges explicitly:
- the synchroniser delay;
- a set that collides with a clear;
- masked pending read-back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    IRQC_LEVEL  = 2'd0,
    IRQC_EDGE   = 2'd1,
    IRQC_LEGACY = 2'd2
  } irqc_mode_e;

  localparam logic SEL_MASK = 1'b0;
  localparam logic SEL_PEND = 1'b1;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= '0;
        else if (g == 0) chain_q[g] <= async_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= chain_q[LAST];
  end

  assign sync_o = chain_q[LAST];
  assign rise_o = chain_q[LAST] & ~prev_q;

  // a rise can only be reported where the previous sample was low
  assert_rise_prev_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & $past(chain_q[LAST])) == '0);
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
#(
  parameter int         WIDTH = 32,
  parameter irqc_mode_e MODE  = IRQC_EDGE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] rise_i,
  input  logic             clr_wr_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] pend_o
);
  generate
    if (MODE == IRQC_LEVEL) begin : g_level
      assign pend_o = level_i;
    end else begin : g_sticky
      logic [WIDTH-1:0] set_v;
      logic [WIDTH-1:0] clr_v;
      logic [WIDTH-1:0] pend_q;

      if (MODE == IRQC_EDGE) begin : g_edge
        assign set_v = rise_i;
        assign clr_v = clr_wr_i ? clr_data_i : '0;
      end else begin : g_legacy
        assign set_v = level_i;
        assign clr_v = clr_wr_i ? ~clr_data_i : '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else pend_q <= (pend_q & ~clr_v) | set_v;
      end
      assign pend_o = pend_q;

      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((pend_q & $past(set_v)) == $past(set_v)));

      assert_clear_R4_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((pend_q & $past(clr_v & ~set_v)) == '0));

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    end
  endgenerate
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int         N_LINES     = 32,
  parameter int         SYNC_STAGES = 2,
  parameter irqc_mode_e MODE        = IRQC_EDGE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               cfg_wr,
  input  logic               cfg_sel,
  input  logic [N_LINES-1:0] cfg_wdata,
  output logic [N_LINES-1:0] cfg_rdata,
  output logic               irq_o
);
  logic [N_LINES-1:0] sync_v;
  logic [N_LINES-1:0] rise_v;
  logic [N_LINES-1:0] pend_v;
  logic [N_LINES-1:0] mask_q;
  logic               irq_q;

  irqc_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_lines),
    .sync_o  (sync_v),
    .rise_o  (rise_v)
  );

  irqc_pending #(.WIDTH(N_LINES), .MODE(MODE)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_i    (sync_v),
    .rise_i     (rise_v),
    .clr_wr_i   (cfg_wr && (cfg_sel == SEL_PEND)),
    .clr_data_i (cfg_wdata),
    .pend_o     (pend_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (cfg_wr && (cfg_sel == SEL_MASK)) mask_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else irq_q <= |(pend_v & mask_q);
  end

  assign cfg_rdata = (cfg_sel == SEL_PEND) ? pend_v : mask_q;
  assign irq_o     = irq_q;

  assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|mask_q));

  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == SEL_MASK) |=> (cfg_sel != SEL_MASK || cfg_rdata == $past(cfg_wdata)));
endmodule

// File: tb/tb_irqc_top.sv
`timescale 1ns/100ps
module tb_irqc_top;
  import irqc_pkg::*;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] lines = '0;
  logic wr = 1'b0;
  logic sel = 1'b0;
  logic [N-1:0] wd = '0;
  logic [N-1:0] rd_e, rd_l, rd_g;
  logic irq_e, irq_l, irq_g;

  int n_tests = 0;
  int n_fail  = 0;
  bit wd_hit  = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top #(.N_LINES(N), .MODE(IRQC_EDGE)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .cfg_wr(wr), .cfg_sel(sel),
    .cfg_wdata(wd), .cfg_rdata(rd_e), .irq_o(irq_e));
  irqc_top #(.N_LINES(N), .MODE(IRQC_LEVEL)) dut_lvl (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .cfg_wr(wr), .cfg_sel(sel),
    .cfg_wdata(wd), .cfg_rdata(rd_l), .irq_o(irq_l));
  irqc_top #(.N_LINES(N), .MODE(IRQC_LEGACY)) dut_leg (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .cfg_wr(wr), .cfg_sel(sel),
    .cfg_wdata(wd), .cfg_rdata(rd_g), .irq_o(irq_g));

  // cycle model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_s3, m_mask, m_pe, m_pg;
  logic m_ie, m_il, m_ig;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_mask <= '0;
      m_pe <= '0; m_pg <= '0; m_ie <= 1'b0; m_il <= 1'b0; m_ig <= 1'b0;
    end else begin
      m_s1 <= lines; m_s2 <= m_s1; m_s3 <= m_s2;
      if (wr && !sel) m_mask <= wd;
      m_pe <= (m_pe & ~((wr && sel) ? wd : '0)) | (m_s2 & ~m_s3);
      m_pg <= (m_pg & ~((wr && sel) ? ~wd : '0)) | m_s2;
      m_ie <= |(m_pe & m_mask);
      m_il <= |(m_s2 & m_mask);
      m_ig <= |(m_pg & m_mask);
    end
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      if (!sel) begin
        chk("R1/R2 mask read edge", rd_e, m_mask);
        chk("R1/R2 mask read level", rd_l, m_mask);
        chk("R1/R2 mask read legacy", rd_g, m_mask);
      end else begin
        chk("R4 pending edge", rd_e, m_pe);
        chk("R5 pending level", rd_l, m_s2);
        chk("R6 pending legacy", rd_g, m_pg);
      end
      chk("R9 irq edge",   {{(N-1){1'b0}}, irq_e}, {{(N-1){1'b0}}, m_ie});
      chk("R9 irq level",  {{(N-1){1'b0}}, irq_l}, {{(N-1){1'b0}}, m_il});
      chk("R9 irq legacy", {{(N-1){1'b0}}, irq_g}, {{(N-1){1'b0}}, m_ig});
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  initial begin : watchdog
    #500000;
    wd_hit = 1'b1;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd4711;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    sel = 1'b0; #1;
    chk("R10 reset mask", rd_e, '0);
    sel = 1'b1; #1;
    chk("R10 reset pending edge", rd_e, '0);
    chk("R10 reset pending legacy", rd_g, '0);
    chk("R10 reset irq", {31'd0, irq_e | irq_l | irq_g}, '0);
    lines = 32'hFFFF_FFFF; step(); step(); step();
    chk("R10 no latch while reset", rd_g, '0);
    lines = '0;
    rst_n = 1'b1;
    step(); step(); step();
    cmp_on = 1'b1;

    // R3 synchroniser delay, level mode, line 5
    sel = 1'b1;
    lines[5] = 1'b1; step();
    chk("R3 one edge: not yet", rd_l & 32'h20, '0);
    step();
    chk("R3 two edges: visible", rd_l & 32'h20, 32'h20);
    lines[5] = 1'b0; step(); step(); step();

    // R7 set collides with clear, line 0
    wr = 1'b1; sel = 1'b1; wd = 32'hFFFF_FFFF; step();  // clear all edge latches
    wd = '0; step();                                   // clear all legacy latches
    wr = 1'b0; step();
    lines[0] = 1'b1; step(); step();                   // rise reaches stage 2
    wr = 1'b1; wd = 32'h0000_0001; step();             // edge clear on bit 0
    wr = 1'b0; #1;
    chk("R7 edge set wins", rd_e & 32'h1, 32'h1);
    wr = 1'b1; wd = 32'hFFFF_FFFE; step();             // legacy clear on bit 0, line still high
    wr = 1'b0; #1;
    chk("R7 legacy set wins", rd_g & 32'h1, 32'h1);
    lines[0] = 1'b0; step(); step(); step();
    wr = 1'b1; wd = 32'hFFFF_FFFE; step(); wr = 1'b0; #1;
    chk("R6 legacy clear by zero", rd_g & 32'h1, 32'h0);
    wr = 1'b1; wd = 32'h0; step(); wr = 1'b0; #1;
    chk("R4 edge clear by zero ignored", rd_e & 32'h1, 32'h1);
    chk("R5 level write ignored", rd_l, '0);

    // R8 masked line still pending, no irq
    wr = 1'b1; sel = 1'b0; wd = '0; step(); wr = 1'b0; sel = 1'b1;
    lines[9] = 1'b1; step(); step(); step(); step();
    chk("R8 masked pending visible edge", rd_e & 32'h200, 32'h200);
    chk("R8 masked no irq", {31'd0, irq_e}, '0);
    wr = 1'b1; sel = 1'b0; wd = 32'h200; step(); wr = 1'b0; step(); #1;
    chk("R9 irq after unmask", {31'd0, irq_e}, 32'h1);
    lines = '0;

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) lines = $urandom;
      else if ($urandom % 2 == 0) lines[$urandom % N] = ~lines[$urandom % N];
      wr  = ($urandom % 5 == 0);
      sel = $urandom % 2;
      wd  = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
      step();
    end
    wr = 1'b0;
    step();
    cmp_on = 1'b0;
    if (!wd_hit) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule